// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It takes two operands and a five-bit condition mask. Each mask bit enables one relation between the operands: signed less-than, signed greater-than, equality, unsigned less-than or unsigned greater-than. If any enabled relation is true, the block raises a trap request. Signed and unsigned relations can be enabled together in one mask, and the result is the logical OR of all enabled relations.

Two operand widths are supported. In doubleword mode all `XLEN` bits of each operand take part. In word mode only the low `WORD_W` bits are used. The block reads them as signed or unsigned according to each relation, and the upper bits have no effect. Instruction decoding happens upstream. The registered trap strobe and cause code go to the exception logic of the core.

Top module: `trap_cmp_unit`

## Requirements
- R1: During and right after reset, `trap_o` is 0 and `cause_o` is 0.
- R2: Mask bit 4 (value 0x10) enables a trap when A is less than B, both read as two's-complement signed.
- R3: Mask bit 3 (value 0x08) enables a trap when A is greater than B, both read as signed.
- R4: Mask bit 2 (value 0x04) enables a trap when A equals B.
- R5: Mask bit 1 (value 0x02) enables a trap when A is less than B as unsigned numbers. Mask bit 0 (value 0x01) enables a trap when A is greater than B as unsigned numbers.
- R6: When several mask bits are set, a trap occurs if at least one of the enabled relations holds.
- R7: When `word_mode` is 1, only bits [WORD_W-1:0] of each operand are compared. Bit WORD_W-1 is the sign bit for the signed relations. Upper operand bits never change the result.
- R8: When `word_mode` is 0, all XLEN bits are compared, and bit XLEN-1 is the sign bit.
- R9: A mask of 0 never traps. A mask of 0x1F always traps when `in_valid` is 1.
- R10: `trap_o` is registered. It goes high exactly one cycle after a cycle where `in_valid` is 1 and the trap condition holds. It stays low after any cycle where `in_valid` is 0.
- R11: `cause_o` equals `TRAP_CAUSE` (default 0x02) in every cycle where `trap_o` is 1, and equals 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks a compare request in this cycle |
| op_a | input | XLEN | First operand |
| op_b | input | XLEN | Second operand |
| cond_flags | input | 5 | Relation enable mask (bit 4 signed lt, 3 signed gt, 2 eq, 1 unsigned lt, 0 unsigned gt) |
| word_mode | input | 1 | 1 selects the low WORD_W bits, 0 selects all XLEN bits |
| trap_o | output | 1 | Trap request, one cycle after the request |
| cause_o | output | CAUSE_W | Program-exception cause, TRAP_CAUSE while trapping, else 0 |

## Verification
The bench builds two copies with the defaults `XLEN=64` and `WORD_W=32`. One uses the shared-subtractor comparison (`CMP_STYLE=1`) and the other uses separate relational comparators (`CMP_STYLE=0`). Both must agree with one behavioural model. The 32-bit word inside a 64-bit operand allows cases where the upper halves disagree while the low words match. It also allows cases where bit 31 alone flips the signed order, so the word-mode truncation and sign choice can be checked against doubleword mode on the same operands.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

   // Width of the relation enable mask
   localparam int FLAG_W = 5;

   // Bit positions of the relations inside the mask; the packed struct
   // below lists them MSB first so that it lines up with the mask.
   localparam int REL_SLT = 4;
   localparam int REL_SGT = 3;
   localparam int REL_EQ  = 2;
   localparam int REL_ULT = 1;
   localparam int REL_UGT = 0;

   typedef struct packed {
      logic slt;
      logic sgt;
      logic eq;
      logic ult;
      logic ugt;
   } rel_t;

   // Comparison implementation choices
   localparam int STYLE_DIRECT = 0;
   localparam int STYLE_SUBTRACT = 1;

endpackage

// File: rtl/trap_cmp_operand.sv
module trap_cmp_operand #(
   parameter int XLEN   = 64,
   parameter int WORD_W = 32
) (
   input  logic [XLEN-1:0] raw_i,
   input  logic            word_mode_i,
   output logic [XLEN-1:0] zext_o,
   output logic [XLEN-1:0] sext_o,
   output logic            sign_o
);

   localparam int EXT_W = XLEN - WORD_W;

   generate
      if (EXT_W == 0) begin : g_same_width
         // Word and doubleword coincide: nothing to condition
         always_comb begin
            zext_o = raw_i;
            sext_o = raw_i;
         end
      end else begin : g_extend
         logic [WORD_W-1:0] low_word;
         always_comb begin
            low_word = raw_i[WORD_W-1:0];
            if (word_mode_i) begin
               zext_o = {{EXT_W{1'b0}}, low_word};
               sext_o = {{EXT_W{low_word[WORD_W-1]}}, low_word};
            end else begin
               zext_o = raw_i;
               sext_o = raw_i;
            end
         end
      end
   endgenerate

   assign sign_o = sext_o[XLEN-1];

endmodule

// File: rtl/trap_cmp_relate.sv
module trap_cmp_relate
   import trap_cmp_pkg::*;
#(
   parameter int XLEN      = 64,
   parameter int CMP_STYLE = STYLE_SUBTRACT
) (
   input  logic [XLEN-1:0] a_zext_i,
   input  logic [XLEN-1:0] b_zext_i,
   input  logic [XLEN-1:0] a_sext_i,
   input  logic [XLEN-1:0] b_sext_i,
   input  logic            a_sign_i,
   input  logic            b_sign_i,
   output rel_t            rel_o
);

   generate
      if (CMP_STYLE == STYLE_DIRECT) begin : g_direct
         // Separate comparators for every relation
         always_comb begin
            rel_o.slt = $signed(a_sext_i) < $signed(b_sext_i);
            rel_o.sgt = $signed(a_sext_i) > $signed(b_sext_i);
            rel_o.eq  = a_zext_i == b_zext_i;
            rel_o.ult = a_zext_i < b_zext_i;
            rel_o.ugt = a_zext_i > b_zext_i;
         end
      end else begin : g_subtract
         // One subtractor provides borrow and zero; the signed order
         // follows from the unsigned order unless the sign bits differ.
         logic [XLEN:0] diff;
         logic          borrow;
         logic          zero;
         logic          signs_differ;
         always_comb begin
            diff         = {1'b0, a_zext_i} - {1'b0, b_zext_i};
            borrow       = diff[XLEN];
            zero         = diff[XLEN-1:0] == '0;
            signs_differ = a_sign_i ^ b_sign_i;
            rel_o.eq     = zero;
            rel_o.ult    = borrow;
            rel_o.ugt    = !borrow && !zero;
            rel_o.slt    = signs_differ ? a_sign_i : borrow;
            rel_o.sgt    = signs_differ ? b_sign_i : (!borrow && !zero);
         end
      end
   endgenerate

endmodule

// File: rtl/trap_cmp_reduce.sv
module trap_cmp_reduce
   import trap_cmp_pkg::*;
(
   input  rel_t              rel_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic              hit_o
);

   logic [FLAG_W-1:0] rel_bits;
   logic [FLAG_W-1:0] enabled;

   assign rel_bits = rel_i;

   generate
      for (genvar i = 0; i < FLAG_W; i++) begin : g_gate
         assign enabled[i] = rel_bits[i] & flags_i[i];
      end
   endgenerate

   assign hit_o = |enabled;

endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
   import trap_cmp_pkg::*;
#(
   parameter int               XLEN       = 64,
   parameter int               WORD_W     = 32,
   parameter int               CAUSE_W    = 8,
   parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 8'h02,
   parameter int               CMP_STYLE  = STYLE_SUBTRACT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [XLEN-1:0]    op_a,
   input  logic [XLEN-1:0]    op_b,
   input  logic [FLAG_W-1:0]  cond_flags,
   input  logic               word_mode,
   output logic               trap_o,
   output logic [CAUSE_W-1:0] cause_o
);

   // Elaboration-time parameter checks
   generate
      if (WORD_W < 2 || WORD_W > XLEN) begin : g_bad_word
         $error("trap_cmp_unit: WORD_W must lie in 2..XLEN");
      end
      if (TRAP_CAUSE == '0) begin : g_bad_cause
         $error("trap_cmp_unit: TRAP_CAUSE must be nonzero");
      end
      if (CMP_STYLE != STYLE_DIRECT && CMP_STYLE != STYLE_SUBTRACT) begin : g_bad_style
         $error("trap_cmp_unit: unknown CMP_STYLE");
      end
   endgenerate

   logic [XLEN-1:0] a_zext, a_sext, b_zext, b_sext;
   logic            a_sign, b_sign;
   rel_t            rel;
   logic            hit;
   logic            fire;

   trap_cmp_operand #(.XLEN(XLEN), .WORD_W(WORD_W)) u_cond_a (
      .raw_i       (op_a),
      .word_mode_i (word_mode),
      .zext_o      (a_zext),
      .sext_o      (a_sext),
      .sign_o      (a_sign)
   );

   trap_cmp_operand #(.XLEN(XLEN), .WORD_W(WORD_W)) u_cond_b (
      .raw_i       (op_b),
      .word_mode_i (word_mode),
      .zext_o      (b_zext),
      .sext_o      (b_sext),
      .sign_o      (b_sign)
   );

   trap_cmp_relate #(.XLEN(XLEN), .CMP_STYLE(CMP_STYLE)) u_relate (
      .a_zext_i (a_zext),
      .b_zext_i (b_zext),
      .a_sext_i (a_sext),
      .b_sext_i (b_sext),
      .a_sign_i (a_sign),
      .b_sign_i (b_sign),
      .rel_o    (rel)
   );

   trap_cmp_reduce u_reduce (
      .rel_i   (rel),
      .flags_i (cond_flags),
      .hit_o   (hit)
   );

   assign fire = in_valid & hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trap_o  <= 1'b0;
         cause_o <= '0;
      end else begin
         trap_o  <= fire;
         cause_o <= fire ? TRAP_CAUSE : '0;
      end
   end

endmodule

// File: rtl/trap_cmp_unit_chk.sv
module trap_cmp_unit_chk
   import trap_cmp_pkg::*;
#(
   parameter int               XLEN       = 64,
   parameter int               CAUSE_W    = 8,
   parameter logic [CAUSE_W-1:0] TRAP_CAUSE = 8'h02
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [XLEN-1:0]    op_a,
   input logic [XLEN-1:0]    op_b,
   input logic [FLAG_W-1:0]  cond_flags,
   input logic               word_mode,
   input logic               trap_o,
   input logic [CAUSE_W-1:0] cause_o
);

   // R10
   no_trap_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !trap_o);

   // R9
   zero_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_flags == '0) |=> !trap_o);

   // R9
   full_mask_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_flags == '1) |=> trap_o);

   // R4
   equal_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_flags == 5'b00100 && !word_mode && op_a == op_b) |=> trap_o);

   // R5
   unsigned_lt_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && cond_flags == 5'b00010 && !word_mode && op_a < op_b) |=> trap_o);

   // R11
   cause_with_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trap_o |-> cause_o == TRAP_CAUSE);

   // R11
   cause_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trap_o |-> cause_o == '0);

endmodule

bind trap_cmp_unit trap_cmp_unit_chk #(
   .XLEN(XLEN), .CAUSE_W(CAUSE_W), .TRAP_CAUSE(TRAP_CAUSE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
   .cond_flags(cond_flags), .word_mode(word_mode), .trap_o(trap_o), .cause_o(cause_o)
);

// File: tb/trap_cmp_unit_bench.sv
module trap_cmp_unit_bench;

   localparam int CLK_P   = 10;
   localparam int XLEN    = 64;
   localparam int CAUSE_W = 8;
   localparam logic [CAUSE_W-1:0] CAUSE = 8'h02;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_valid = 1'b0;
   logic [XLEN-1:0] op_a = '0;
   logic [XLEN-1:0] op_b = '0;
   logic [4:0]      cond_flags = '0;
   logic            word_mode = 1'b0;
   logic            trap_sub, trap_dir;
   logic [CAUSE_W-1:0] cause_sub, cause_dir;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   trap_cmp_unit #(.CMP_STYLE(1)) u_trap_cmp_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .cond_flags(cond_flags), .word_mode(word_mode),
      .trap_o(trap_sub), .cause_o(cause_sub)
   );

   trap_cmp_unit #(.CMP_STYLE(0)) u_trap_cmp_unit_direct (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
      .cond_flags(cond_flags), .word_mode(word_mode),
      .trap_o(trap_dir), .cause_o(cause_dir)
   );

   function automatic logic model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [4:0] f, input logic wm);
      logic signed [63:0] sa, sb;
      logic [63:0] ua, ub;
      sa = wm ? {{32{a[31]}}, a[31:0]} : a;
      sb = wm ? {{32{b[31]}}, b[31:0]} : b;
      ua = wm ? {32'h0, a[31:0]} : a;
      ub = wm ? {32'h0, b[31:0]} : b;
      return (f[4] && sa < sb) || (f[3] && sa > sb) || (f[2] && ua == ub) ||
             (f[1] && ua < ub) || (f[0] && ua > ub);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic outputs_are(input string req, input logic t);
      chk(req, {31'b0, trap_sub}, {31'b0, t});
      chk(req, {31'b0, trap_dir}, {31'b0, t});
      chk("R11", {24'b0, cause_sub}, t ? {24'b0, CAUSE} : 32'h0);
      chk("R11", {24'b0, cause_dir}, t ? {24'b0, CAUSE} : 32'h0);
   endtask

   // Called at a falling edge; returns at the next falling edge after checking
   task automatic run(input logic [63:0] a, input logic [63:0] b,
                      input logic [4:0] f, input logic wm, input string req);
      op_a = a; op_b = b; cond_flags = f; word_mode = wm; in_valid = 1'b1;
      @(negedge clk);
      outputs_are(req, model(a, b, f, wm));
      in_valid = 1'b0;
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] ra, rb;
      logic [4:0]  rf;
      int unsigned seed_dummy;
      seed_dummy = $urandom(32'h5eed_0c7);
      repeat (3) @(negedge clk);
      outputs_are("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      outputs_are("R1", 1'b0);

      // R2 signed less-than, doubleword: -1 < 0
      run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'h10, 1'b0, "R2");
      // R3 signed greater-than
      run(64'h5, 64'hFFFF_FFFF_FFFF_FFF0, 5'h08, 1'b0, "R3");
      run(64'hFFFF_FFFF_FFFF_FFF0, 64'h5, 5'h08, 1'b0, "R3");
      // R4 equality
      run(64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b0, "R4");
      // R5 unsigned relations: all ones is the largest unsigned value
      run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'h01, 1'b0, "R5");
      run(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 5'h02, 1'b0, "R5");
      // R6 mixed mask: signed lt true, unsigned gt also true
      run(64'h8000_0000_0000_0000, 64'h1, 5'h12, 1'b0, "R6");
      run(64'h8000_0000_0000_0000, 64'h1, 5'h11, 1'b0, "R6");
      // R7 word mode: upper halves differ, low words equal
      run(64'h1_0000_0005, 64'h2_0000_0005, 5'h04, 1'b1, "R7");
      // R8 same operands in doubleword mode
      run(64'h1_0000_0005, 64'h2_0000_0005, 5'h04, 1'b0, "R8");
      // R7 bit 31 is the sign in word mode
      run(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b1, "R7");
      run(64'h0000_0000_8000_0000, 64'h1, 5'h02, 1'b1, "R7");
      // R8 bit 31 is an ordinary bit in doubleword mode
      run(64'h0000_0000_8000_0000, 64'h1, 5'h10, 1'b0, "R8");
      // R9 empty and full masks
      run(64'h7, 64'h7, 5'h00, 1'b0, "R9");
      run(64'h7, 64'h9, 5'h1F, 1'b1, "R9");
      run(64'h9, 64'h9, 5'h1F, 1'b0, "R9");
      // R10 no request, mask that would always fire
      op_a = 64'h3; op_b = 64'h3; cond_flags = 5'h1F; in_valid = 1'b0;
      @(negedge clk);
      outputs_are("R10", 1'b0);

      // Random mix with back-to-back requests
      for (int i = 0; i < 3000; i++) begin
         ra = {$urandom, $urandom};
         rb = {$urandom, $urandom};
         case ($urandom % 4)
            0: rb = ra;
            1: rb = {rb[63:32], ra[31:0]};
            2: rb[31] = ~ra[31];
            default: ;
         endcase
         rf = 5'($urandom);
         run(ra, rb, rf, 1'($urandom), "R6");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule